// File: doc/BRIEF.md
# Read Strobe Delay Centering Engine

This block trains the read-capture delay of every byte lane of one memory channel. Each delay has a coarse part and a fine part, and eight fine steps make one coarse step. For each lane in turn, the engine programs a trial delay into that lane's control register and asks an external tester whether the lane then reads correctly. From the answers it finds the lowest passing delay and the first failing delay above the passing window. It then programs the midpoint of the two.

The engine sees the delay as one linear number, `coarse*8 + fine`. Every step moves this number by +8, -8 or +1. It then clips the number into the legal range. Clipping at the top ends the upper-edge search with a saturated edge. Clipping during the lower-edge search aborts training.

Register writes use a valid/ready port. `wr_valid` rises with `wr_data` and `lane` and keeps all three stable until the cycle in which `wr_ready` is high. The write is taken in that cycle. A low `wr_ready` only stalls the engine. The tester handshake is level based. `tst_req` stays high until a cycle with `tst_done` high, and `tst_pass` is sampled in that same cycle.

Top module: `rsc_center_engine`

## Requirements
- R1: The delay has a coarse value t from 0 to 13 and a fine value p from 0 to 7, with linear value t*8+p. Every write puts t in bits 23:20 and p in bits 18:16, and sets bits 26:25 to 1. All other bits are copied from the lane image that was read through `img_rdata` when the lane started.
- R2: The lower search starts at 0.0 and raises t by one while the test fails. If the first passing t is 0, the lower edge is 0.0. Otherwise t steps back by one and p rises by one (carrying into t) until the test passes. The lower edge is that passing point.
- R3: The upper search starts at the lower edge plus one coarse step. If that point fails, it is the upper edge. Otherwise t rises until the test fails, then steps back one, then p rises until the test fails. The upper edge is that failing point.
- R4: When an upper-search step would pass 13.7, the upper edge becomes 13.7. That point is neither written nor tested, and the engine goes on to the midpoint.
- R5: When a lower-search step would pass 13.7, nothing more is written or tested, `error` rises, and `done` does not pulse.
- R6: The last write for a lane carries (lower + upper) >> 1 in linear form, split back into t and p.
- R7: Lanes 0 to 7 are trained in increasing order. `lane` addresses both the image read and the write.
- R8: `wr_valid`, `wr_data` and `lane` stay stable until `wr_ready`. `tst_req` rises only after a write has been accepted and is never high together with `wr_valid`.
- R9: `tst_req` stays high until a cycle with `tst_done`, and it is low in the cycle after that.
- R10: `done` is high for exactly one cycle: the cycle after lane 7's midpoint write is accepted.
- R11: `error` stays high until the next `start`, which clears it.
- R12: `start` has no effect while training is in progress.
- R13: After reset, `wr_valid`, `tst_req`, `done` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin training of all lanes (taken only when idle) |
| lane | output | 3 | Lane being trained; selects image read and write target |
| img_rdata | input | 32 | Current control register image of `lane` |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted when high with `wr_valid` |
| wr_data | output | 32 | Register word to write to `lane` |
| tst_req | output | 1 | Request a pass/fail test at the programmed delay |
| tst_done | input | 1 | Test result is valid this cycle |
| tst_pass | input | 1 | Test outcome, sampled with `tst_done` |
| done | output | 1 | One-cycle pulse when all lanes are centered |
| error | output | 1 | Lower search overflowed; held until next start |

## Verification
The bench gives each lane its own passing window on the linear delay scale. A window that starts at 0 checks that the lower search stops without a step back. A window narrower than one coarse step makes the upper start point fail. A window reaching 13.7 forces upper saturation. A window that starts on a coarse boundary or between boundaries separates the coarse pass from the fine pass. An empty window on a middle lane drives the fatal lower overflow, and the next run checks that `error` clears. Irregular `wr_ready` stalls, varying tester latency and a stray `start` in mid-run check that the same write sequence still results.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WRITE,
    ST_TEST,
    ST_MID
  } rsc_state_t;

  typedef enum logic [2:0] {
    PH_LO_COARSE,
    PH_LO_FINE,
    PH_UP_START,
    PH_UP_COARSE,
    PH_UP_FINE,
    PH_CENTER
  } rsc_phase_t;

endpackage

// File: rtl/rsc_delay_step.sv
// Moves a linear delay by a fixed signed amount and clips to [0, LIN_MAX].
module rsc_delay_step #(
  parameter int LIN_W   = 7,
  parameter int LIN_MAX = 111,
  parameter int DELTA   = 1
) (
  input  logic [LIN_W-1:0] base,
  output logic [LIN_W-1:0] next,
  output logic             clip
);
  localparam int SW = LIN_W + 2;
  localparam logic signed [SW-1:0] D_S   = SW'(DELTA);
  localparam logic signed [SW-1:0] MAX_S = SW'(LIN_MAX);

  logic signed [SW-1:0] sum;
  logic                 below, above;

  assign sum   = $signed({2'b00, base}) + D_S;
  assign below = sum[SW-1];
  assign above = !below && (sum > MAX_S);
  assign clip  = below || above;

  always_comb begin
    if (below)      next = '0;
    else if (above) next = LIN_W'(LIN_MAX);
    else            next = sum[LIN_W-1:0];
  end
endmodule

// File: rtl/rsc_field_merge.sv
// Builds a lane control word from the captured image and a linear delay.
module rsc_field_merge #(
  parameter int REG_W   = 32,
  parameter int LIN_W   = 7,
  parameter int P_BITS  = 3,
  parameter int T_LSB   = 20,
  parameter int T_BITS  = 4,
  parameter int P_LSB   = 16,
  parameter int SET_LSB = 25,
  parameter int SET_W   = 2
) (
  input  logic [REG_W-1:0] image,
  input  logic [LIN_W-1:0] lin,
  output logic [REG_W-1:0] word
);
  localparam int TW = LIN_W - P_BITS;

  logic [TW-1:0]     t_val;
  logic [P_BITS-1:0] p_val;

  assign t_val = lin[LIN_W-1:P_BITS];
  assign p_val = lin[P_BITS-1:0];

  always_comb begin
    word                     = image;
    word[T_LSB +: T_BITS]    = T_BITS'(t_val);
    word[P_LSB +: P_BITS]    = p_val;
    word[SET_LSB +: SET_W]   = '1;
  end
endmodule

// File: rtl/rsc_lane_seq.sv
module rsc_lane_seq #(
  parameter  int LANES  = 8,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [LANE_W-1:0] lane,
  output logic              last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) lane <= '0;
    else if (adv)      lane <= lane + 1'b1;
  end

  assign last = (lane == LANE_W'(LANES - 1));
endmodule

// File: rtl/rsc_center_engine.sv
module rsc_center_engine
  import rsc_pkg::*;
#(
  parameter  int LANES    = 8,
  parameter  int T_LEVELS = 14,
  parameter  int P_BITS   = 3,
  parameter  int REG_W    = 32,
  parameter  int T_LSB    = 20,
  parameter  int T_BITS   = 4,
  parameter  int P_LSB    = 16,
  parameter  int SET_LSB  = 25,
  parameter  int SET_W    = 2,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [LANE_W-1:0] lane,
  input  logic [REG_W-1:0]  img_rdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [REG_W-1:0]  wr_data,
  output logic              tst_req,
  input  logic              tst_done,
  input  logic              tst_pass,
  output logic              done,
  output logic              error
);
  localparam int P_STEPS = 1 << P_BITS;
  localparam int LIN_MAX = T_LEVELS * P_STEPS - 1;
  localparam int LIN_W   = $clog2(LIN_MAX + 1);
  localparam int N_STEP  = 3;
  localparam int S_UP    = 0;
  localparam int S_DN    = 1;
  localparam int S_FINE  = 2;

  rsc_state_t state_q, state_d;
  rsc_phase_t phase_q, phase_d;
  logic [LIN_W-1:0] lin_q, lin_d, lo_q, lo_d, up_q, up_d;
  logic [REG_W-1:0] image_q;
  logic             img_ld, lane_clr, lane_adv, lane_last;
  logic             err_set, err_clr, done_d;
  logic [LIN_W:0]   mid_sum;

  logic [LIN_W-1:0] step_nxt [N_STEP];
  logic [N_STEP-1:0] step_clip;

  // Three steppers: coarse up, coarse down, fine up
  for (genvar g = 0; g < N_STEP; g++) begin : g_step
    localparam int D = (g == S_UP) ? P_STEPS : ((g == S_DN) ? -P_STEPS : 1);
    rsc_delay_step #(.LIN_W(LIN_W), .LIN_MAX(LIN_MAX), .DELTA(D)) u_step (
      .base(lin_q),
      .next(step_nxt[g]),
      .clip(step_clip[g])
    );
  end

  rsc_lane_seq #(.LANES(LANES)) u_seq (
    .clk (clk),
    .rst_n(rst_n),
    .clr (lane_clr),
    .adv (lane_adv),
    .lane(lane),
    .last(lane_last)
  );

  rsc_field_merge #(
    .REG_W(REG_W), .LIN_W(LIN_W), .P_BITS(P_BITS), .T_LSB(T_LSB),
    .T_BITS(T_BITS), .P_LSB(P_LSB), .SET_LSB(SET_LSB), .SET_W(SET_W)
  ) u_merge (
    .image(image_q),
    .lin  (lin_q),
    .word (wr_data)
  );

  assign mid_sum = {1'b0, lo_q} + {1'b0, up_q};

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    lin_d    = lin_q;
    lo_d     = lo_q;
    up_d     = up_q;
    img_ld   = 1'b0;
    lane_clr = 1'b0;
    lane_adv = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          lane_clr = 1'b1;
          err_clr  = 1'b1;
          state_d  = ST_LOAD;
        end
      end
      ST_LOAD: begin
        img_ld  = 1'b1;
        lin_d   = '0;
        phase_d = PH_LO_COARSE;
        state_d = ST_WRITE;
      end
      ST_WRITE: begin
        if (wr_ready) begin
          if (phase_q == PH_CENTER) begin
            if (lane_last) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              lane_adv = 1'b1;
              state_d  = ST_LOAD;
            end
          end else begin
            state_d = ST_TEST;
          end
        end
      end
      ST_TEST: begin
        if (tst_done) begin
          unique case (phase_q)
            PH_LO_COARSE, PH_LO_FINE: begin
              if (tst_pass && (phase_q == PH_LO_FINE || lin_q == '0)) begin
                // lower edge found; open the upper search one coarse step above
                lo_d = lin_q;
                if (step_clip[S_UP]) begin
                  up_d    = LIN_W'(LIN_MAX);
                  state_d = ST_MID;
                end else begin
                  lin_d   = step_nxt[S_UP];
                  phase_d = PH_UP_START;
                  state_d = ST_WRITE;
                end
              end else if (tst_pass) begin
                lin_d   = step_nxt[S_DN];
                phase_d = PH_LO_FINE;
                state_d = ST_WRITE;
              end else begin
                if (step_clip[(phase_q == PH_LO_FINE) ? S_FINE : S_UP]) begin
                  err_set = 1'b1;
                  state_d = ST_IDLE;
                end else begin
                  lin_d   = step_nxt[(phase_q == PH_LO_FINE) ? S_FINE : S_UP];
                  state_d = ST_WRITE;
                end
              end
            end
            PH_UP_START, PH_UP_COARSE: begin
              if (tst_pass) begin
                if (step_clip[S_UP]) begin
                  up_d    = LIN_W'(LIN_MAX);
                  state_d = ST_MID;
                end else begin
                  lin_d   = step_nxt[S_UP];
                  phase_d = PH_UP_COARSE;
                  state_d = ST_WRITE;
                end
              end else if (phase_q == PH_UP_START) begin
                up_d    = lin_q;
                state_d = ST_MID;
              end else begin
                lin_d   = step_nxt[S_DN];
                phase_d = PH_UP_FINE;
                state_d = ST_WRITE;
              end
            end
            PH_UP_FINE: begin
              if (!tst_pass) begin
                up_d    = lin_q;
                state_d = ST_MID;
              end else if (step_clip[S_FINE]) begin
                up_d    = LIN_W'(LIN_MAX);
                state_d = ST_MID;
              end else begin
                lin_d   = step_nxt[S_FINE];
                state_d = ST_WRITE;
              end
            end
            default: state_d = ST_IDLE;
          endcase
        end
      end
      ST_MID: begin
        lin_d   = mid_sum[LIN_W:1];
        phase_d = PH_CENTER;
        state_d = ST_WRITE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_LO_COARSE;
      lin_q   <= '0;
      lo_q    <= '0;
      up_q    <= '0;
      image_q <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      lin_q   <= lin_d;
      lo_q    <= lo_d;
      up_q    <= up_d;
      done    <= done_d;
      if (img_ld)       image_q <= img_rdata;
      if (err_clr)      error   <= 1'b0;
      else if (err_set) error   <= 1'b1;
    end
  end

  assign wr_valid = (state_q == ST_WRITE);
  assign tst_req  = (state_q == ST_TEST);

  // Checks on the engine's own behaviour
  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(lane));

  assert_req_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tst_req) |-> $past(wr_valid && wr_ready));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tst_req && !tst_done |=> tst_req);

  assert_field_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[T_LSB +: T_BITS] < T_BITS'(T_LEVELS)) && (wr_data[SET_LSB +: SET_W] == '1));

  assert_mid_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && phase_q == PH_CENTER |-> (lin_q >= lo_q) && (lin_q <= up_q));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_MID |-> up_q > lo_q);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_error_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error);

  assert_quiet_after_fatal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !wr_valid && !tst_req);
endmodule

// File: tb/test_rsc_center_engine.sv
module test_rsc_center_engine;
  localparam int LANES = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  lane;
  logic [31:0] img_rdata;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_data;
  logic        tst_req;
  logic        tst_done = 1'b0;
  logic        tst_pass = 1'b0;
  logic        done;
  logic        error;

  always #10 clk = ~clk;

  logic [31:0] regs [LANES];
  assign img_rdata = regs[lane];

  rsc_center_engine i_rsc_center_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .lane(lane), .img_rdata(img_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tst_req(tst_req), .tst_done(tst_done), .tst_pass(tst_pass),
    .done(done), .error(error)
  );

  int checks = 0;
  int errors = 0;
  int win_lo [LANES];
  int win_hi [LANES];
  int          q_ln  [$];
  logic [31:0] q_dat [$];
  string       q_tag [$];
  bit exp_err = 0;
  bit arm_err = 0;
  bit seen_done = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit pass_at(int ln, int t, int p);
    int v = t * 8 + p;
    return (v >= win_lo[ln]) && (v <= win_hi[ln]);
  endfunction

  // carry fine into coarse, clip to 0.0 .. 13.7; returns 0 on clipping
  function automatic bit norm(inout int t, inout int p);
    while (p >= 8) begin t++; p -= 8; end
    while (p < 0)  begin t--; p += 8; end
    if (t < 0)   begin t = 0;  p = 0; return 0; end
    if (t >= 14) begin t = 13; p = 7; return 0; end
    return 1;
  endfunction

  function automatic logic [31:0] word_of(logic [31:0] base, int t, int p);
    logic [31:0] w = base & ~32'h00F7_0000;
    return w | 32'h0600_0000 | (32'(t) << 20) | (32'(p) << 16);
  endfunction

  task automatic push(int ln, logic [31:0] base, int t, int p, string tag);
    q_ln.push_back(ln);
    q_dat.push_back(word_of(base, t, p));
    q_tag.push_back(tag);
  endtask

  // Behavioural model of the search: expected write sequence for a whole run
  task automatic build_model();
    q_ln.delete(); q_dat.delete(); q_tag.delete();
    exp_err = 0;
    for (int ln = 0; ln < LANES; ln++) begin
      logic [31:0] base = regs[ln];
      int lt = 0, lp = 0, ut, up, mid;
      bit ok;
      push(ln, base, 0, 0, "R2");
      while (!pass_at(ln, lt, lp)) begin
        lt++;
        if (!norm(lt, lp)) begin exp_err = 1; return; end
        push(ln, base, lt, lp, "R2");
      end
      if (lt > 0) begin
        lt--;
        push(ln, base, lt, lp, "R2");
        while (!pass_at(ln, lt, lp)) begin
          lp++;
          if (!norm(lt, lp)) begin exp_err = 1; return; end
          push(ln, base, lt, lp, "R2");
        end
      end
      ut = lt + 1; up = lp;
      if (norm(ut, up)) begin
        push(ln, base, ut, up, "R3");
        if (pass_at(ln, ut, up)) begin
          ok = 1;
          do begin
            ut++;
            ok = norm(ut, up);
            if (ok) push(ln, base, ut, up, "R3");
          end while (ok && pass_at(ln, ut, up));
          if (ok) begin
            ut--;
            push(ln, base, ut, up, "R3");
            while (ok && pass_at(ln, ut, up)) begin
              up++;
              ok = norm(ut, up);
              if (ok) push(ln, base, ut, up, "R3");
            end
          end
        end
      end
      mid = ((lt * 8 + lp) + (ut * 8 + up)) / 2;
      push(ln, base, mid / 8, mid % 8, "R6");
    end
  endtask

  // Per-clock monitor, tester model and write sink
  initial begin
    int cyc = 0;
    int wait_c = 0;
    bit pend = 0;
    logic [31:0] pend_dat = '0;
    bit fin_pend = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        chk(done == fin_pend, "R10", "done pulse", done, fin_pend);
        fin_pend = 0;
        if (done) seen_done = 1;
        chk(!(wr_valid && tst_req), "R8", "write and test overlap", {wr_valid, tst_req}, 0);
        if (arm_err && (q_ln.size() > 0 || !exp_err))
          chk(error == 0, "R11", "error during good training", error, 0);
        if (pend) chk(wr_valid && wr_data == pend_dat, "R8", "write held under stall", wr_data, pend_dat);
        // tester
        if (tst_done) begin
          tst_done = 0;
          chk(tst_req == 0, "R9", "request dropped after done", tst_req, 0);
        end else if (tst_req) begin
          if (wait_c == 0) begin
            tst_done = 1;
            tst_pass = pass_at(int'(lane), int'(regs[lane][23:20]), int'(regs[lane][18:16]));
            wait_c = cyc % 3;
          end else wait_c--;
        end
        // write sink with back-pressure
        wr_ready = (cyc % 4) != 1;
        pend = wr_valid && !wr_ready;
        pend_dat = wr_data;
        if (wr_valid && wr_ready) begin
          if (q_ln.size() == 0) begin
            chk(0, "R5", "unexpected write", wr_data, 0);
          end else begin
            chk(int'(lane) == q_ln[0], "R7", "lane order", lane, q_ln[0]);
            chk(wr_data == q_dat[0], q_tag[0], "written word", wr_data, q_dat[0]);
            void'(q_ln.pop_front()); void'(q_dat.pop_front()); void'(q_tag.pop_front());
            if (q_ln.size() == 0 && !exp_err) fin_pend = 1;
          end
          regs[lane] = wr_data;
        end
      end
    end
  end

  task automatic run(bit stray_start);
    build_model();
    seen_done = 0;
    arm_err = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; arm_err = 1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      start = stray_start && (i == 50);
      if (seen_done || (exp_err && error && q_ln.size() == 0)) break;
    end
    start = 0;
    repeat (10) @(negedge clk);
    chk(q_ln.size() == 0, "R7", "all expected writes seen", q_ln.size(), 0);
    chk(seen_done == !exp_err, "R10", "done seen", seen_done, !exp_err);
    chk(error == exp_err, "R5", "error state", error, exp_err);
    chk(wr_valid == 0 && tst_req == 0, "R5", "engine quiet at end", {wr_valid, tst_req}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] init0, init2;
    for (int i = 0; i < LANES; i++) regs[i] = 32'h9C3F_A5E1 + 32'(i) * 32'h0111_0101;
    init0 = regs[0];
    init2 = regs[2];
    repeat (3) @(negedge clk);
    chk(wr_valid == 0 && tst_req == 0, "R13", "handshakes idle in reset", {wr_valid, tst_req}, 0);
    chk(done == 0 && error == 0, "R13", "status low in reset", {done, error}, 0);
    rst_n = 1;
    @(negedge clk);

    // Run 1: varied windows, stray start mid-run
    win_lo = '{0, 30, 50, 100, 5, 63, 16, 70};
    win_hi = '{40, 33, 111, 111, 20, 64, 16, 90};
    run(1);
    chk(seen_done, "R12", "stray start did not disturb run", seen_done, 1);
    chk(regs[0] == word_of(init0, 2, 4), "R1", "lane 0 final word", regs[0], word_of(init0, 2, 4));
    chk(regs[1][23:16] == 8'h42, "R3", "narrow window centre 4.2", regs[1][23:16], 8'h42);
    chk(regs[2] == word_of(init2, 10, 0), "R4", "saturated upper centre 10.0", regs[2], word_of(init2, 10, 0));
    chk(regs[6][23:16] == 8'h24, "R2", "single point window centre 2.4", regs[6][23:16], 8'h24);

    // Run 2: lane 1 never passes -> fatal lower overflow
    win_lo = '{10, 500, 10, 10, 10, 10, 10, 10};
    win_hi = '{30, 500, 30, 30, 30, 30, 30, 30};
    run(0);
    chk(error == 1, "R5", "fatal overflow flagged", error, 1);
    repeat (20) @(negedge clk);
    chk(error == 1, "R11", "error held while idle", error, 1);

    // Run 3: start clears error, fresh windows
    for (int i = 0; i < LANES; i++) begin
      win_lo[i] = i * 10 + 3;
      win_hi[i] = i * 10 + 40;
    end
    run(0);
    chk(error == 0, "R11", "error cleared by start", error, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule